// File: doc/BRIEF.md
# Abstract Register Access Sequencer

This block turns a debugger's "access register" command into a short run of 32-bit RISC-V instructions. It writes them, one word per cycle, into the abstract-command buffer that a halted hart executes from. After the last word it raises a one-cycle go pulse for the hart the command selected. The instruction encoders are combinational. The block holds one command at a time. It latches the command, the data-area address and the two buffer base addresses when it accepts the command, and it ignores new commands until the sequence is written.

The register number picks the template. Numbers below 0x1000 are CSRs, 0x1000..0x101F are integer registers and 0x1020..0x103F are floating-point registers. A CSR transfer goes through s0. It parks s0 in the debug scratch CSR (0x7B2) first and takes it back at the end. This path exists only when the program buffer is shorter than two words. The final word is an ebreak, or a jump into the program buffer when post-execution is requested. A command the block cannot serve leaves the buffer untouched, raises no go pulse and sets the error code. The hart's execution of the words is outside this block.

Top module: `abstract_access_seq`

## Requirements
- R1: After reset `busy`, `buf_we` and `go` are 0 and `cmd_err` is 0.
- R2: With transfer set, size code 2 or 3 and register number 0x1000..0x101F, word 0 is a single integer access to register (regno-0x1000). A write emits a load into that register (opcode 0x03). A read emits a store from that register (opcode 0x23). Base register is x0, the immediate is `data_addr`, and funct3 is 2 for size code 2 and 3 for size code 3.
- R3: With transfer set, size code 2 or 3 and register number 0x1020..0x103F, word 0 is one FP access to register (regno-0x1020). A write emits a load (opcode 0x07) and a read emits a store (opcode 0x27). Base register, immediate and funct3 follow R2.
- R4: With transfer set, register number below 0x1000, size code 2 or 3 and PROGBUF_WORDS < 2, words 0..3 are written as follows. Word 0 is csrrw x0,0x7B2,s0. For a write, word 1 is a load into s0 and word 2 is csrrw x0,regno,s0. For a read, word 1 is csrrs s0,regno,x0 and word 2 is a store of s0. Word 3 is csrrs s0,0x7B2,x0. The loads and stores use the addressing of R2.
- R5: With transfer set, a size code other than 2 or 3, or a register number of 0x1040 or above, sets `cmd_err` to 2 one cycle after acceptance, with no buffer write and no go pulse. Any accepted command that is served sets `cmd_err` to 0.
- R6: The final word, at index n after n access words, is jal x0 with offset (progbuf_addr - abs_addr - 4*n) when post-execute is set, and 0x00100073 (ebreak) otherwise.
- R7: With transfer clear, the register number and size are ignored and only the final word is written, at index 0.
- R8: Buffer writes begin the cycle after acceptance at index 0 and continue on consecutive cycles with indices rising by one. The cycle after the last write, `go` carries a one-hot bit for the latched hart for exactly one cycle.
- R9: A command presented while `busy` is 1 is ignored. It changes neither the words being written, nor the go target, nor `cmd_err`.
- R10: With PROGBUF_WORDS of 2 or more, a CSR command (register number below 0x1000, transfer set) gets `cmd_err` 2 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_regno | input | 16 | Register number |
| cmd_size | input | 3 | Size code (2 = 32-bit, 3 = 64-bit) |
| cmd_write | input | 1 | 1 = write the register from the data area |
| cmd_transfer | input | 1 | Perform the register access |
| cmd_postexec | input | 1 | Chain into the program buffer afterwards |
| cmd_hart | input | HART_W | Hart that receives the go pulse |
| data_addr | input | 12 | Data-area address, used as x0-relative immediate |
| progbuf_addr | input | 12 | Program-buffer base address |
| abs_addr | input | 12 | Abstract-command buffer base address |
| busy | output | 1 | Sequence being written |
| buf_we | output | 1 | Buffer word write strobe |
| buf_idx | output | IDX_W | Buffer word index |
| buf_word | output | 32 | Instruction word |
| cmd_err | output | 3 | 0 = none, 2 = not supported |
| go | output | NUM_HARTS | One-cycle go pulse, one bit per hart |

## Verification
The hardest case to reach from the ports is a second command that arrives in the middle of a five-word CSR sequence. The stimulus holds `cmd_valid` high with a different register, hart and post-execute setting for several cycles of that sequence. The reference model then requires every word, the go target and the error code to match the first command only. The unsupported CSR case needs a program buffer of two or more words, so a second instance with that setting runs from the same stimulus and its error and strobe are checked directly. Jump offsets are covered with the program buffer placed both above and below the abstract buffer, so the scrambled immediate is checked with both signs.

// File: rtl/asq_pkg.sv
package asq_pkg;

    localparam int          DBG_AW      = 12;
    localparam int          JOFF_W      = 21;
    localparam logic [15:0] GPR_FIRST   = 16'h1000;
    localparam logic [15:0] FPR_FIRST   = 16'h1020;
    localparam logic [15:0] REG_END     = 16'h1040;
    localparam logic [2:0]  SZ_W32      = 3'd2;
    localparam logic [2:0]  SZ_W64      = 3'd3;
    localparam logic [2:0]  ERR_NONE    = 3'd0;
    localparam logic [2:0]  ERR_NOTSUP  = 3'd2;
    localparam int          CSR_BODY    = 4;
    localparam int          XFER_BODY   = 1;

    localparam logic [4:0]  R_ZERO      = 5'd0;
    localparam logic [4:0]  R_S0        = 5'd8;
    localparam logic [11:0] CSR_SCRATCH = 12'h7B2;

    localparam logic [6:0]  OPC_LOAD    = 7'h03;
    localparam logic [6:0]  OPC_FLOAD   = 7'h07;
    localparam logic [6:0]  OPC_STORE   = 7'h23;
    localparam logic [6:0]  OPC_FSTORE  = 7'h27;
    localparam logic [6:0]  OPC_SYSTEM  = 7'h73;
    localparam logic [6:0]  OPC_JAL     = 7'h6F;
    localparam logic [2:0]  F3_CSRRW    = 3'd1;
    localparam logic [2:0]  F3_CSRRS    = 3'd2;
    localparam logic [31:0] WORD_EBREAK = 32'h0010_0073;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_GPR,
        PATH_FPR,
        PATH_CSR
    } path_e;

    typedef struct packed {
        logic [15:0] regno;
        logic [2:0]  size;
        logic        wr;
        logic        xfer;
        logic        post;
    } acc_cmd_t;

    typedef struct packed {
        path_e              path;
        logic               wr;
        logic               wide;
        logic [4:0]         rnum;
        logic [11:0]        csr;
        logic               post;
        logic [11:0]        dimm;
        logic [JOFF_W-1:0]  jdist;
    } seq_ctx_t;

    function automatic logic [31:0] enc_itype(input logic [11:0] imm, input logic [4:0] rs1,
                                              input logic [2:0] f3, input logic [4:0] rd,
                                              input logic [6:0] opc);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_stype(input logic [11:0] imm, input logic [4:0] rs2,
                                              input logic [4:0] rs1, input logic [2:0] f3,
                                              input logic [6:0] opc);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    function automatic logic [31:0] enc_csr(input logic [11:0] csr, input logic [4:0] rs1,
                                            input logic [2:0] f3, input logic [4:0] rd);
        return {csr, rs1, f3, rd, OPC_SYSTEM};
    endfunction

    function automatic logic [31:0] enc_jal(input logic [4:0] rd, input logic [JOFF_W-1:0] off);
        return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
    endfunction

endpackage

// File: rtl/asq_decode.sv
module asq_decode
    import asq_pkg::*;
#(
    parameter int PROGBUF_WORDS = 1,
    parameter int IDX_W         = 3
) (
    input  acc_cmd_t            cmd,
    input  logic [DBG_AW-1:0]   data_addr,
    input  logic [DBG_AW-1:0]   progbuf_addr,
    input  logic [DBG_AW-1:0]   abs_addr,
    output seq_ctx_t            ctx,
    output logic [IDX_W-1:0]    last_idx,
    output logic                bad
);

    localparam bit CSR_OK = (PROGBUF_WORDS < 2);

    logic              size_ok;
    logic [DBG_AW:0]   diff;
    logic [JOFF_W-1:0] jdist;

    assign size_ok = (cmd.size == SZ_W32) || (cmd.size == SZ_W64);
    assign diff    = {1'b0, progbuf_addr} - {1'b0, abs_addr};
    assign jdist   = {{(JOFF_W-DBG_AW-1){diff[DBG_AW]}}, diff};

    always_comb begin
        ctx       = '0;
        ctx.path  = PATH_NONE;
        ctx.wr    = cmd.wr;
        ctx.wide  = (cmd.size == SZ_W64);
        ctx.rnum  = cmd.regno[4:0];
        ctx.csr   = cmd.regno[11:0];
        ctx.post  = cmd.post;
        ctx.dimm  = data_addr;
        ctx.jdist = jdist;
        last_idx  = '0;
        bad       = 1'b0;
        if (cmd.xfer) begin
            if (cmd.regno < GPR_FIRST) begin
                if (CSR_OK && size_ok) begin
                    ctx.path = PATH_CSR;
                    last_idx = IDX_W'(CSR_BODY);
                end else begin
                    bad = 1'b1;
                end
            end else if (cmd.regno < FPR_FIRST) begin
                if (size_ok) begin
                    ctx.path = PATH_GPR;
                    last_idx = IDX_W'(XFER_BODY);
                end else begin
                    bad = 1'b1;
                end
            end else if (cmd.regno < REG_END) begin
                if (size_ok) begin
                    ctx.path = PATH_FPR;
                    last_idx = IDX_W'(XFER_BODY);
                end else begin
                    bad = 1'b1;
                end
            end else begin
                bad = 1'b1;
            end
        end
    end

endmodule

// File: rtl/asq_emit.sv
module asq_emit
    import asq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  seq_ctx_t          ctx,
    input  logic [IDX_W-1:0]  idx,
    output logic [31:0]       word
);

    logic [2:0]        f3;
    logic [IDX_W-1:0]  nbody;
    logic [JOFF_W-1:0] joff;
    logic [31:0]       final_w;
    logic [31:0]       ld_s0;
    logic [31:0]       st_s0;

    assign f3      = ctx.wide ? 3'd3 : 3'd2;
    assign joff    = ctx.jdist - (JOFF_W'(idx) << 2);
    assign final_w = ctx.post ? enc_jal(R_ZERO, joff) : WORD_EBREAK;
    assign ld_s0   = enc_itype(ctx.dimm, R_ZERO, f3, R_S0, OPC_LOAD);
    assign st_s0   = enc_stype(ctx.dimm, R_S0, R_ZERO, f3, OPC_STORE);

    always_comb begin
        case (ctx.path)
            PATH_CSR:             nbody = IDX_W'(CSR_BODY);
            PATH_GPR, PATH_FPR:   nbody = IDX_W'(XFER_BODY);
            default:              nbody = '0;
        endcase
    end

    always_comb begin
        word = final_w;
        if (idx != nbody) begin
            case (ctx.path)
                PATH_GPR:
                    word = ctx.wr ? enc_itype(ctx.dimm, R_ZERO, f3, ctx.rnum, OPC_LOAD)
                                  : enc_stype(ctx.dimm, ctx.rnum, R_ZERO, f3, OPC_STORE);
                PATH_FPR:
                    word = ctx.wr ? enc_itype(ctx.dimm, R_ZERO, f3, ctx.rnum, OPC_FLOAD)
                                  : enc_stype(ctx.dimm, ctx.rnum, R_ZERO, f3, OPC_FSTORE);
                PATH_CSR: begin
                    case (idx)
                        IDX_W'(0): word = enc_csr(CSR_SCRATCH, R_S0, F3_CSRRW, R_ZERO);
                        IDX_W'(1): word = ctx.wr ? ld_s0
                                                 : enc_csr(ctx.csr, R_ZERO, F3_CSRRS, R_S0);
                        IDX_W'(2): word = ctx.wr ? enc_csr(ctx.csr, R_S0, F3_CSRRW, R_ZERO)
                                                 : st_s0;
                        default:   word = enc_csr(CSR_SCRATCH, R_ZERO, F3_CSRRS, R_S0);
                    endcase
                end
                default: word = final_w;
            endcase
        end
    end

endmodule

// File: rtl/asq_ctrl.sv
module asq_ctrl
    import asq_pkg::*;
#(
    parameter int IDX_W     = 3,
    parameter int NUM_HARTS = 4,
    parameter int HART_W    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  seq_ctx_t              dec_ctx,
    input  logic [IDX_W-1:0]      dec_last,
    input  logic                  dec_bad,
    input  logic [HART_W-1:0]     cmd_hart,
    output logic                  busy,
    output logic [IDX_W-1:0]      cnt,
    output seq_ctx_t              ctx,
    output logic [2:0]            err,
    output logic [NUM_HARTS-1:0]  go
);

    typedef enum logic {ST_IDLE, ST_FILL} st_e;

    st_e                   st_q;
    logic [IDX_W-1:0]      cnt_q;
    logic [IDX_W-1:0]      last_q;
    logic [HART_W-1:0]     hart_q;
    seq_ctx_t              ctx_q;
    logic [2:0]            err_q;
    logic [NUM_HARTS-1:0]  go_q;
    logic [NUM_HARTS-1:0]  hot;

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hot
        assign hot[h] = (hart_q == HART_W'(h));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            last_q <= '0;
            hart_q <= '0;
            ctx_q  <= '0;
            err_q  <= ERR_NONE;
            go_q   <= '0;
        end else begin
            go_q <= '0;
            case (st_q)
                ST_FILL: begin
                    if (cnt_q == last_q) begin
                        st_q <= ST_IDLE;
                        go_q <= hot;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cmd_valid) begin
                        if (dec_bad) begin
                            err_q <= ERR_NOTSUP;
                        end else begin
                            err_q  <= ERR_NONE;
                            st_q   <= ST_FILL;
                            cnt_q  <= '0;
                            last_q <= dec_last;
                            hart_q <= cmd_hart;
                            ctx_q  <= dec_ctx;
                        end
                    end
                end
            endcase
        end
    end

    assign busy = (st_q == ST_FILL);
    assign cnt  = cnt_q;
    assign ctx  = ctx_q;
    assign err  = err_q;
    assign go   = go_q;

endmodule

// File: rtl/abstract_access_seq.sv
module abstract_access_seq
    import asq_pkg::*;
#(
    parameter int PROGBUF_WORDS = 1,
    parameter int ABS_WORDS     = 8,
    parameter int NUM_HARTS     = 4,
    localparam int IDX_W        = $clog2(ABS_WORDS),
    localparam int HART_W       = $clog2(NUM_HARTS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [15:0]           cmd_regno,
    input  logic [2:0]            cmd_size,
    input  logic                  cmd_write,
    input  logic                  cmd_transfer,
    input  logic                  cmd_postexec,
    input  logic [HART_W-1:0]     cmd_hart,
    input  logic [11:0]           data_addr,
    input  logic [11:0]           progbuf_addr,
    input  logic [11:0]           abs_addr,
    output logic                  busy,
    output logic                  buf_we,
    output logic [IDX_W-1:0]      buf_idx,
    output logic [31:0]           buf_word,
    output logic [2:0]            cmd_err,
    output logic [NUM_HARTS-1:0]  go
);

    acc_cmd_t          cmd;
    seq_ctx_t          dec_ctx;
    seq_ctx_t          run_ctx;
    logic [IDX_W-1:0]  dec_last;
    logic              dec_bad;
    logic [IDX_W-1:0]  cnt;
    logic              busy_i;

    assign cmd = '{regno: cmd_regno, size: cmd_size, wr: cmd_write,
                   xfer: cmd_transfer, post: cmd_postexec};

    asq_decode #(.PROGBUF_WORDS(PROGBUF_WORDS), .IDX_W(IDX_W)) u_decode (
        .cmd          (cmd),
        .data_addr    (data_addr),
        .progbuf_addr (progbuf_addr),
        .abs_addr     (abs_addr),
        .ctx          (dec_ctx),
        .last_idx     (dec_last),
        .bad          (dec_bad)
    );

    asq_ctrl #(.IDX_W(IDX_W), .NUM_HARTS(NUM_HARTS), .HART_W(HART_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .dec_ctx   (dec_ctx),
        .dec_last  (dec_last),
        .dec_bad   (dec_bad),
        .cmd_hart  (cmd_hart),
        .busy      (busy_i),
        .cnt       (cnt),
        .ctx       (run_ctx),
        .err       (cmd_err),
        .go        (go)
    );

    asq_emit #(.IDX_W(IDX_W)) u_emit (
        .ctx  (run_ctx),
        .idx  (cnt),
        .word (buf_word)
    );

    assign busy    = busy_i;
    assign buf_we  = busy_i;
    assign buf_idx = cnt;

endmodule

// File: rtl/asq_chk.sv
module asq_chk
    import asq_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic                  busy,
    input logic [IDX_W-1:0]      buf_idx,
    input logic [2:0]            cmd_err,
    input logic [NUM_HARTS-1:0]  go
);

    // R8
    start_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> buf_idx == '0);

    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || buf_idx == IDX_W'($past(buf_idx) + 1'b1)));

    // R8
    go_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (go != '0) |-> ($past(busy) && !busy));

    // R8
    go_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go));

    // R5
    err_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy) |=> (busy ? cmd_err == ERR_NONE : cmd_err == ERR_NOTSUP));

    // R9
    err_frozen_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_err));

endmodule

bind abstract_access_seq asq_chk #(.NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .buf_idx   (buf_idx),
    .cmd_err   (cmd_err),
    .go        (go)
);

// File: tb/abstract_access_seq_bench.sv
module abstract_access_seq_bench;

    localparam int PBW   = 1;
    localparam int AW    = 8;
    localparam int NH    = 4;
    localparam int IW    = $clog2(AW);
    localparam int HW    = $clog2(NH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [15:0]   cmd_regno = '0;
    logic [2:0]    cmd_size = '0;
    logic          cmd_write = 1'b0;
    logic          cmd_transfer = 1'b0;
    logic          cmd_postexec = 1'b0;
    logic [HW-1:0] cmd_hart = '0;
    logic [11:0]   data_addr = 12'h380;
    logic [11:0]   progbuf_addr = 12'h300;
    logic [11:0]   abs_addr = 12'h2E0;

    logic          busy, buf_we, busy2, we2;
    logic [IW-1:0] buf_idx, idx2;
    logic [31:0]   buf_word, word2;
    logic [2:0]    cmd_err, err2;
    logic [NH-1:0] go, go2;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    abstract_access_seq #(.PROGBUF_WORDS(PBW), .ABS_WORDS(AW), .NUM_HARTS(NH)) u_abstract_access_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_regno(cmd_regno),
        .cmd_size(cmd_size), .cmd_write(cmd_write), .cmd_transfer(cmd_transfer),
        .cmd_postexec(cmd_postexec), .cmd_hart(cmd_hart), .data_addr(data_addr),
        .progbuf_addr(progbuf_addr), .abs_addr(abs_addr), .busy(busy),
        .buf_we(buf_we), .buf_idx(buf_idx), .buf_word(buf_word),
        .cmd_err(cmd_err), .go(go));

    abstract_access_seq #(.PROGBUF_WORDS(2), .ABS_WORDS(AW), .NUM_HARTS(NH)) u_abstract_access_seq_pb2 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_regno(cmd_regno),
        .cmd_size(cmd_size), .cmd_write(cmd_write), .cmd_transfer(cmd_transfer),
        .cmd_postexec(cmd_postexec), .cmd_hart(cmd_hart), .data_addr(data_addr),
        .progbuf_addr(progbuf_addr), .abs_addr(abs_addr), .busy(busy2),
        .buf_we(we2), .buf_idx(idx2), .buf_word(word2),
        .cmd_err(err2), .go(go2));

    // reference model state
    logic [31:0] m_q[$];
    bit          m_busy = 0;
    int          m_idx = 0;
    int          m_hart = 0;
    int          m_go = 0;
    int          m_err = 0;
    string       m_tag = "R1";

    function automatic logic [31:0] t_load(bit fp, int rd, int f3, int imm);
        return 32'(((imm & 'hFFF) << 20) | (f3 << 12) | (rd << 7) | (fp ? 'h07 : 'h03));
    endfunction

    function automatic logic [31:0] t_store(bit fp, int rs2, int f3, int imm);
        return 32'((((imm >> 5) & 'h7F) << 25) | (rs2 << 20) | (f3 << 12) |
                   ((imm & 'h1F) << 7) | (fp ? 'h27 : 'h23));
    endfunction

    function automatic logic [31:0] t_csr(int csr, int rs1, int f3, int rd);
        return 32'((csr << 20) | (rs1 << 15) | (f3 << 12) | (rd << 7) | 'h73);
    endfunction

    function automatic logic [31:0] t_jal(int off);
        int j;
        j = off & 'h1FFFFF;
        return 32'((((j >> 20) & 1) << 31) | (((j >> 1) & 'h3FF) << 21) |
                   (((j >> 11) & 1) << 20) | (((j >> 12) & 'hFF) << 12) | 'h6F);
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(busy == m_busy, m_tag, "busy", busy, m_busy);
        chk(buf_we == m_busy, m_tag, "buf_we", buf_we, m_busy);
        if (m_busy) begin
            chk(int'(buf_idx) == m_idx, "R8", "buf_idx", buf_idx, m_idx);
            chk(buf_word == m_q[0], m_tag, "buf_word", buf_word, m_q[0]);
        end
        chk(int'(go) == m_go, "R8", "go", go, m_go);
        chk(int'(cmd_err) == m_err, m_tag, "cmd_err", cmd_err, m_err);
    endtask

    task automatic build(int regno, int size, bit wr, bit xfer, bit post, int hart, string tag);
        int  f3;
        bit  sz_ok;
        bit  bad;
        f3    = (size == 3) ? 3 : 2;
        sz_ok = (size == 2) || (size == 3);
        bad   = 0;
        m_q.delete();
        if (xfer) begin
            if (regno < 'h1000) begin
                if (PBW < 2 && sz_ok) begin
                    m_q.push_back(t_csr('h7B2, 8, 1, 0));
                    if (wr) begin
                        m_q.push_back(t_load(0, 8, f3, int'(data_addr)));
                        m_q.push_back(t_csr(regno & 'hFFF, 8, 1, 0));
                    end else begin
                        m_q.push_back(t_csr(regno & 'hFFF, 0, 2, 8));
                        m_q.push_back(t_store(0, 8, f3, int'(data_addr)));
                    end
                    m_q.push_back(t_csr('h7B2, 0, 2, 8));
                end else bad = 1;
            end else if (regno < 'h1040 && sz_ok) begin
                bit fp;
                fp = (regno >= 'h1020);
                if (wr) m_q.push_back(t_load(fp, regno & 'h1F, f3, int'(data_addr)));
                else    m_q.push_back(t_store(fp, regno & 'h1F, f3, int'(data_addr)));
            end else bad = 1;
        end
        if (bad) begin
            m_err = 2;
            m_q.delete();
        end else begin
            int n;
            n = m_q.size();
            if (post) m_q.push_back(t_jal(int'(progbuf_addr) - int'(abs_addr) - 4 * n));
            else      m_q.push_back(32'h0010_0073);
            m_err  = 0;
            m_busy = 1;
            m_idx  = 0;
            m_hart = hart;
        end
        m_tag = tag;
    endtask

    task automatic tick(bit v, int regno, int size, bit wr, bit xfer, bit post, int hart, string tag);
        @(negedge clk);
        compare();
        cmd_valid    = v;
        cmd_regno    = 16'(regno);
        cmd_size     = 3'(size);
        cmd_write    = wr;
        cmd_transfer = xfer;
        cmd_postexec = post;
        cmd_hart     = HW'(hart);
        m_go = 0;
        if (m_busy) begin
            if (v) m_tag = "R9";
            void'(m_q.pop_front());
            m_idx++;
            if (m_q.size() == 0) begin
                m_busy = 0;
                m_go   = 1 << m_hart;
            end
        end else if (v) begin
            build(regno, size, wr, xfer, post, hart, tag);
        end
    endtask

    task automatic idle_wait();
        for (int k = 0; k < 12; k++) tick(0, 0, 0, 0, 0, 0, 0, m_tag);
    endtask

    task automatic run(int regno, int size, bit wr, bit xfer, bit post, int hart, string tag);
        tick(1, regno, size, wr, xfer, post, hart, tag);
        idle_wait();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state compared on the first tick
        tick(0, 0, 0, 0, 0, 0, 0, "R1");

        // R2 integer register write / read
        run('h100A, 2, 1, 1, 0, 1, "R2");
        run('h101F, 3, 0, 1, 0, 2, "R2");
        // R3 floating-point register write / read
        run('h1020, 3, 1, 1, 0, 3, "R3");
        run('h103F, 2, 0, 1, 0, 0, "R3");
        // R4 CSR write / read through s0
        run('h0300, 3, 1, 1, 0, 1, "R4");
        run('h07B0, 2, 0, 1, 0, 2, "R4");
        // R6 post-execute jump, program buffer above the abstract buffer
        run('h1005, 2, 1, 1, 1, 3, "R6");
        run('h0341, 3, 1, 1, 1, 0, "R6");
        // R6 program buffer below the abstract buffer: negative offset
        progbuf_addr = 12'h100;
        abs_addr     = 12'h800;
        run('h0C00, 2, 0, 1, 1, 1, "R6");
        run('h1021, 3, 0, 1, 1, 2, "R6");
        // R5 unsupported commands
        run('h1001, 4, 1, 1, 0, 1, "R5");
        run('h1030, 1, 0, 1, 1, 2, "R5");
        run('h1040, 2, 1, 1, 0, 3, "R5");
        run('hFFFF, 3, 0, 1, 1, 0, "R5");
        // R7 no transfer: regno and size ignored
        run('hFFFF, 7, 1, 0, 1, 2, "R7");
        run('h0000, 0, 0, 0, 0, 3, "R7");
        // R9 command held while busy
        progbuf_addr = 12'h340;
        abs_addr     = 12'h320;
        tick(1, 'h0305, 2, 1, 1, 1, 1, "R4");
        for (int k = 0; k < 4; k++) tick(1, 'h1040, 5, 0, 1, 0, 3, "R9");
        idle_wait();

        // R10 CSR unsupported when the program buffer has two or more words
        tick(1, 'h0300, 2, 1, 1, 0, 0, "R4");
        tick(0, 0, 0, 0, 0, 0, 0, m_tag);
        chk(err2 == 3'd2, "R10", "pb2 cmd_err", err2, 2);
        chk(we2 == 1'b0, "R10", "pb2 buf_we", we2, 0);
        idle_wait();
        tick(1, 'h1003, 2, 1, 1, 0, 1, "R2");
        tick(0, 0, 0, 0, 0, 0, 0, m_tag);
        chk(err2 == 3'd0, "R10", "pb2 cmd_err after gpr", err2, 0);
        chk(we2 == 1'b1, "R10", "pb2 buf_we after gpr", we2, 1);
        idle_wait();

        finish_run();
    end

endmodule